// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Bank

This block is a parameterized general-purpose I/O bank on a single-cycle synchronous register bus. Each bus cycle carries at most one access: a write selected by `bus_wr` or a read selected by `bus_rd`, at a 3-bit word offset. The bank holds an output latch that drives `pin_out`, and a direction state that drives `pin_oe`. It also samples `pin_in` through a two-flop synchronizer. There is one GPIO line per register bit, so `WIDTH` sets both the register size and the number of lines.

Software can update the output latch in three ways. It can load the whole latch through the data word. It can raise selected bits through a write-one-to-set word, or drop selected bits through a write-one-to-clear word. Direction is visible through two words that always read as exact complements: one where a 1 marks an output, and one where a 1 marks an input.

Two elaboration options adapt the bank to the software that uses it. The first reverses the line-to-bit numbering in every word. The second makes the set word read back the output latch.

Top module: `gpio_mmreg`

## Requirements
- R1: `WIDTH` is 8, 16, 32 or 64 and the bank has exactly `WIDTH` lines. After reset, `pin_out` and `pin_oe` are all zeros, `bus_rdata` is zero, the output-direction word (offset 3) reads all zeros and the input-direction word (offset 4) reads all ones.
- R2: A write to the data word (offset 0) loads the whole output latch from `bus_wdata`, and `pin_out` shows the new value after that clock edge.
- R3: A write to the set word (offset 1) forces to 1 each latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R4: A write to the clear word (offset 2) forces to 0 each latch bit whose write-data bit is 1 and leaves every other latch bit unchanged.
- R5: Writing the output-direction word (offset 3) makes lines with a 1 outputs (`pin_oe` high) and the rest inputs. Writing the input-direction word (offset 4) makes lines with a 1 inputs and the rest outputs. At all times the input-direction word reads as the bitwise complement of the output-direction word.
- R6: A read of the data word returns the `pin_in` levels after a two-flop synchronizer. A level applied before clock edge k is returned by a read whose strobe is sampled at edge k+2 or later, and not by one sampled at edge k or k+1.
- R7: `bus_rdata` is registered. It takes the selected word at the clock edge that samples `bus_rd` high, and it holds its value in cycles without a read.
- R8: Reads of the clear word and of the unmapped offsets 5, 6 and 7 return zero. When the read-back option `RD_OUT_VIA_SET` is off, reads of the set word also return zero.
- R9: When `RD_OUT_VIA_SET` is on, a read of the set word returns the output latch.
- R10: When `MIRROR` is on, line n corresponds to register bit WIDTH-1-n in every word, for both reads and writes. When `MIRROR` is off, line n corresponds to bit n.
- R11: Without a write to offsets 0 through 4, the output latch and the direction state hold. Writes to offsets 5 through 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 3 | Word offset of the access |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| pin_in | input | WIDTH | Asynchronous pin input levels, indexed by line |
| pin_out | output | WIDTH | Output latch, indexed by line |
| pin_oe | output | WIDTH | Output enable per line, 1 = output |

## Verification
A write takes effect on `pin_out` and `pin_oe` at the edge that samples the strobe, so the bench compares the pins at the falling edge that follows it. Read data appears one edge after the strobe and is compared at the next falling edge, after the strobe has dropped. Input levels need two synchronizer edges before a read can pick them up. The bench therefore follows every random pin change with idle cycles, and it checks the directed boundary with back-to-back reads: the two reads sampled first still return the old level, and the third returns the new one. Two instances share the same stimulus: one is plain, and the other is mirrored with set-word read-back. Each is checked against its own line-ordered model.

// File: rtl/mmgpio_pkg.sv
package mmgpio_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_SET  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CLR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_DOUT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_DIN  = 3'd4;

  // One-hot write selection after decode
  typedef struct packed {
    logic load;
    logic set;
    logic clr;
    logic dout;
    logic din;
  } wr_sel_t;

endpackage

// File: rtl/mmgpio_rst_sync.sv
module mmgpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/mmgpio_sync.sv
module mmgpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/mmgpio_bitmap.sv
module mmgpio_bitmap #(
  parameter int W      = 32,
  parameter bit MIRROR = 1'b0
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (MIRROR) begin : g_rev
      for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = din[W-1-i];
      end
    end else begin : g_thru
      assign dout = din;
    end
  endgenerate

endmodule

// File: rtl/mmgpio_state.sv
module mmgpio_state
  import mmgpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_sel_t      wsel_i,
  input  logic [W-1:0] wline_i,
  output logic [W-1:0] lat_o,
  output logic [W-1:0] oe_o
);

  logic [W-1:0] lat_q, lat_d;
  logic [W-1:0] oe_q,  oe_d;
  logic         lat_en, oe_en;

  // Next-state logic: one access per cycle, so the selects never overlap
  always_comb begin
    lat_en = wsel_i.load | wsel_i.set | wsel_i.clr;
    oe_en  = wsel_i.dout | wsel_i.din;
    lat_d  = lat_q;
    oe_d   = oe_q;
    if (wsel_i.load) lat_d = wline_i;
    if (wsel_i.set)  lat_d = lat_q | wline_i;
    if (wsel_i.clr)  lat_d = lat_q & ~wline_i;
    if (wsel_i.dout) oe_d  = wline_i;
    if (wsel_i.din)  oe_d  = ~wline_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q <= '0;
    end else if (oe_en) begin
      oe_q <= oe_d;
    end
  end

  assign lat_o = lat_q;
  assign oe_o  = oe_q;

  // R2
  a_r2_full_load: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_i.load |=> lat_q == $past(wline_i));
  // R3
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_i.set |=> lat_q == ($past(lat_q) | $past(wline_i)));
  // R4
  a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_i.clr |=> lat_q == ($past(lat_q) & ~$past(wline_i)));
  // R5
  a_r5_dir_out: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_i.dout |=> oe_q == $past(wline_i));
  a_r5_dir_in: assert property (@(posedge clk) disable iff (!rst_n)
    wsel_i.din |=> oe_q == ~$past(wline_i));
  // R11
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel_i == '0) |=> ($stable(lat_q) && $stable(oe_q)));
  a_r11_one_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wsel_i));

endmodule

// File: rtl/mmgpio_rdmux.sv
module mmgpio_rdmux
  import mmgpio_pkg::*;
#(
  parameter int W      = 32,
  parameter bit RD_SET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      pins_reg_i,
  input  logic [W-1:0]      lat_reg_i,
  input  logic [W-1:0]      oe_reg_i,
  output logic [W-1:0]      rdata_o
);

  logic [W-1:0] rdata_q, rdata_d;

  always_comb begin
    unique case (addr_i)
      OFS_DATA: rdata_d = pins_reg_i;
      OFS_SET:  rdata_d = RD_SET ? lat_reg_i : '0;
      OFS_DOUT: rdata_d = oe_reg_i;
      OFS_DIN:  rdata_d = ~oe_reg_i;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

  // R7
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_q));
  // R8
  a_r8_zero_words: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && (addr_i == OFS_CLR || addr_i > OFS_DIN)) |=> rdata_q == '0);
  // R8 and R9
  a_r9_set_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == OFS_SET) |=> rdata_q == (RD_SET ? $past(lat_reg_i) : '0));
  // R6
  a_r6_data_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && addr_i == OFS_DATA) |=> rdata_q == $past(pins_reg_i));

endmodule

// File: rtl/gpio_mmreg.sv
module gpio_mmreg
  import mmgpio_pkg::*;
#(
  parameter int WIDTH          = 32,
  parameter bit MIRROR         = 1'b0,
  parameter bit RD_OUT_VIA_SET = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe
);

  localparam bit WIDTH_OK = (WIDTH == 8) || (WIDTH == 16) || (WIDTH == 32) || (WIDTH == 64);

  // R1: only the four register sizes are legal
  generate
    if (!WIDTH_OK) begin : g_bad_width
      $error("gpio_mmreg: WIDTH must be 8, 16, 32 or 64");
    end
  endgenerate

  logic             rst_sync_n;
  wr_sel_t          wsel;
  logic [WIDTH-1:0] wline;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] lat_line, oe_line;
  logic [WIDTH-1:0] pins_reg, lat_reg, oe_reg;

  mmgpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Write decode
  always_comb begin
    wsel      = '0;
    wsel.load = bus_wr && (bus_addr == OFS_DATA);
    wsel.set  = bus_wr && (bus_addr == OFS_SET);
    wsel.clr  = bus_wr && (bus_addr == OFS_CLR);
    wsel.dout = bus_wr && (bus_addr == OFS_DOUT);
    wsel.din  = bus_wr && (bus_addr == OFS_DIN);
  end

  // Register bit order to line order
  mmgpio_bitmap #(.W(WIDTH), .MIRROR(MIRROR)) u_map_wr (
    .din  (bus_wdata),
    .dout (wline)
  );

  mmgpio_sync #(.W(WIDTH)) u_sync (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .async_i (pin_in),
    .sync_o  (pins_sync)
  );

  mmgpio_state #(.W(WIDTH)) u_state (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wsel_i  (wsel),
    .wline_i (wline),
    .lat_o   (lat_line),
    .oe_o    (oe_line)
  );

  // Line order back to register bit order
  mmgpio_bitmap #(.W(WIDTH), .MIRROR(MIRROR)) u_map_pins (
    .din  (pins_sync),
    .dout (pins_reg)
  );

  mmgpio_bitmap #(.W(WIDTH), .MIRROR(MIRROR)) u_map_lat (
    .din  (lat_line),
    .dout (lat_reg)
  );

  mmgpio_bitmap #(.W(WIDTH), .MIRROR(MIRROR)) u_map_oe (
    .din  (oe_line),
    .dout (oe_reg)
  );

  mmgpio_rdmux #(.W(WIDTH), .RD_SET(RD_OUT_VIA_SET)) u_rdmux (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rd_i       (bus_rd),
    .addr_i     (bus_addr),
    .pins_reg_i (pins_reg),
    .lat_reg_i  (lat_reg),
    .oe_reg_i   (oe_reg),
    .rdata_o    (bus_rdata)
  );

  assign pin_out = lat_line;
  assign pin_oe  = oe_line;

  // R10: a write to the data word lands on the pins in the configured order
  a_r10_order: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_wr && bus_addr == OFS_DATA) |=>
      pin_out == (MIRROR ? {<<{$past(bus_wdata)}} : $past(bus_wdata)));

endmodule

// File: tb/gpio_mmreg_bench.sv
`timescale 1ns/1ps
module gpio_mmreg_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   addr;
  logic         wr, rd;
  logic [W-1:0] wdata, pin_in;
  logic [W-1:0] rdata_a, pout_a, poe_a;
  logic [W-1:0] rdata_b, pout_b, poe_b;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // Line-ordered models: a = plain, b = mirrored with set read-back
  logic [W-1:0] lat_a, oe_a, lat_b, oe_b;
  logic [W-1:0] last_a, last_b;

  always #4 clk = ~clk;

  gpio_mmreg #(.WIDTH(W)) u_gpio_mmreg (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .pin_in(pin_in),
    .pin_out(pout_a), .pin_oe(poe_a)
  );

  gpio_mmreg #(.WIDTH(W), .MIRROR(1'b1), .RD_OUT_VIA_SET(1'b1)) u_gpio_mmreg_mir (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .pin_in(pin_in),
    .pin_out(pout_b), .pin_oe(poe_b)
  );

  function automatic logic [W-1:0] rev(input logic [W-1:0] x);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = x[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] apply(input logic [2:0] a, input logic [W-1:0] cur,
                                         input logic [W-1:0] v, input bit is_dir);
    if (!is_dir) begin
      case (a)
        3'd0:    return v;
        3'd1:    return cur | v;
        3'd2:    return cur & ~v;
        default: return cur;
      endcase
    end else begin
      case (a)
        3'd3:    return v;
        3'd4:    return ~v;
        default: return cur;
      endcase
    end
  endfunction

  function automatic logic [W-1:0] exp_rd(input logic [2:0] a, input bit mir,
                                          input logic [W-1:0] lat, input logic [W-1:0] oe);
    logic [W-1:0] v;
    case (a)
      3'd0:    v = pin_in;
      3'd1:    v = mir ? lat : '0;
      3'd3:    v = oe;
      3'd4:    v = ~oe;
      default: v = '0;
    endcase
    return mir ? rev(v) : v;
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string wr_tag(input logic [2:0] a);
    case (a)
      3'd0:    return "R2 data load";
      3'd1:    return "R3 set";
      3'd2:    return "R4 clear";
      3'd3:    return "R5 dirout";
      3'd4:    return "R5 dirin";
      default: return "R11 unmapped write";
    endcase
  endfunction

  // All tasks start and end at a falling edge
  task automatic do_write(input logic [2:0] a, input logic [W-1:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    lat_a = apply(a, lat_a, d, 1'b0);
    oe_a  = apply(a, oe_a, d, 1'b1);
    lat_b = apply(a, lat_b, rev(d), 1'b0);
    oe_b  = apply(a, oe_b, rev(d), 1'b1);
    chk({wr_tag(a), " pin_out"}, pout_a, lat_a);
    chk({wr_tag(a), " pin_oe"}, poe_a, oe_a);
    chk({wr_tag(a), " R10 mirrored pin_out"}, pout_b, lat_b);
    chk({wr_tag(a), " R10 mirrored pin_oe"}, poe_b, oe_b);
  endtask

  task automatic do_read(input logic [2:0] a, input string tag);
    logic [W-1:0] ea, eb;
    ea = exp_rd(a, 1'b0, lat_a, oe_a);
    eb = exp_rd(a, 1'b1, lat_b, oe_b);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    chk({tag, " plain"}, rdata_a, ea);
    chk({tag, " R10 mirrored"}, rdata_b, eb);
    last_a = rdata_a;
    last_b = rdata_b;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] old_pins;
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0; pin_in = '0;
    lat_a = '0; oe_a = '0; lat_b = '0; oe_b = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset pin_out", pout_a, '0);
    chk("R1 reset pin_oe", poe_a, '0);
    chk("R1 reset rdata", rdata_a, '0);
    chk("R1 reset mirrored pin_oe", poe_b, '0);
    do_read(3'd3, "R1 reset dirout");
    do_read(3'd4, "R1 reset dirin");

    // Directed register behaviour
    do_write(3'd0, 32'hA5A5_3C3C);
    do_write(3'd1, 32'h0000_FFFF);
    do_write(3'd2, 32'hF000_0001);
    do_read(3'd1, "R9 R8 set readback");
    do_write(3'd3, 32'h0F0F_0F0F);
    do_read(3'd4, "R5 dirin complement");
    do_write(3'd4, 32'h00FF_00FF);
    do_read(3'd3, "R5 dirout complement");
    do_write(3'd1, 32'h0);
    do_write(3'd2, 32'h0);
    do_write(3'd5, 32'hFFFF_FFFF);
    do_write(3'd6, 32'hFFFF_FFFF);
    do_write(3'd7, 32'h1234_5678);
    do_read(3'd0, "R6 data pins");
    do_read(3'd2, "R8 clear word");
    do_read(3'd5, "R8 unmapped 5");
    do_read(3'd7, "R8 unmapped 7");

    // R7 hold without read
    @(negedge clk);
    chk("R7 rdata hold", rdata_a, last_a);
    chk("R7 rdata hold mirrored", rdata_b, last_b);

    // R6 synchronizer latency boundary
    set_pins(32'h1111_2222);
    do_read(3'd0, "R6 settled");
    old_pins = pin_in;
    pin_in = 32'hDEAD_BEEF;
    addr = 3'd0; rd = 1'b1;
    @(negedge clk);
    chk("R6 first read old", rdata_a, old_pins);
    @(negedge clk);
    chk("R6 second read old", rdata_a, old_pins);
    @(negedge clk);
    rd = 1'b0;
    chk("R6 third read new", rdata_a, 32'hDEAD_BEEF);
    chk("R6 R10 third read mirrored", rdata_b, rev(32'hDEAD_BEEF));

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 8;
      if (op < 5) begin
        do_write(3'($urandom % 8), $urandom);
      end else if (op < 7) begin
        do_read(3'($urandom % 8), "R2-path random read R5 R8 R9");
      end else begin
        set_pins($urandom);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule